// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

This block moves a block of words between one peripheral and main memory over a bus that it shares with the processor. Software sets up the job through a small register-write port. It writes the first memory address, the number of words and the peripheral address. It then writes a control word that carries the direction, the path mode and a start bit. The controller asks for the bus one word at a time. After each word it hands the bus back, so the processor is held up only on its next bus access and never changes context. When the last word has moved, the controller raises an interrupt.

Two paths are available. On the integrated path, each word crosses the bus once, going straight between the peripheral port and memory in a single granted cycle. On the detached path, each word needs two separate grants. In one grant the word goes from its source into a holding register inside the controller. In a second grant it goes from that register to its destination.

Both peripheral data ports are valid/ready streams, and a word moves only in a cycle where valid and ready are both high. The inbound stream (`dev_in_*`) must hold `dev_in_valid` and `dev_in_data` steady until the word is accepted. The controller raises `dev_in_ready` only while it holds the bus. On the outbound stream (`dev_out_*`), the controller raises `dev_out_valid` only while it holds the bus. It keeps the word steady, and keeps the bus, until the peripheral takes the word with `dev_out_ready`.

Top module: `cs_dma_engine`

## Requirements
- R1: Each register write is steered by `cfg_sel`. Code 0 sets the memory start address, code 1 the word count, code 2 the peripheral address (shown on `dev_addr`), and code 3 is the control word. In the control word, bit 0 starts a transfer, bit 1 picks the direction (0 = peripheral to memory, 1 = memory to peripheral), bit 2 picks the path (0 = integrated, 1 = detached) and bit 3 clears the interrupt.
- R2: On the integrated path, each word uses exactly one bus grant. In that grant the word goes between the peripheral stream and memory.
- R3: On the detached path, each word uses exactly two bus grants. The first moves the word from its source into the controller, and the second moves it from the controller to its destination.
- R4: `mem_en`, `dev_in_ready` and `dev_out_valid` are high only while `bus_gnt` is high. The controller raises `bus_req` for a word only once the peripheral side can take part: inbound valid for peripheral-to-memory, outbound ready for memory-to-peripheral.
- R5: Each grant moves at most one word. `bus_req` is low in the cycle after every memory write.
- R6: Word k of a block uses memory address (start + k) modulo 2^AW. Words reach their destination in order, and memory outside the block is left unchanged.
- R7: `irq` rises when the last word of a block has moved. It stays high until a control write with bit 3 set.
- R8: A start with a word count of 0 sets `irq` in the next cycle and never raises `bus_req`.
- R9: While `busy` is high, a start command and any write to the start address, count, peripheral address, direction or path is ignored.
- R10: On the outbound stream, a word is counted as delivered only on a cycle with valid and ready both high. While ready is low, the controller keeps the word steady and keeps the bus.
- R11: After reset, `bus_req`, `mem_en`, `busy` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select code |
| cfg_wdata | input | DW | Register write data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while the request stays high |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Memory write (read when low) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |
| dev_addr | output | DAW | Programmed peripheral address |
| dev_in_valid | input | 1 | Inbound word valid |
| dev_in_ready | output | 1 | Inbound word accepted |
| dev_in_data | input | DW | Inbound word |
| dev_out_valid | output | 1 | Outbound word valid |
| dev_out_ready | input | 1 | Peripheral takes the outbound word |
| dev_out_data | output | DW | Outbound word |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with DW=8, AW=4, CW=4 and DAW=4. The 16-word memory is small enough that the bench can compare every location after each run. A start address of 13 with up to four words makes the address wrap past the top of memory. The sweep covers both paths, both directions, every count from 0 to 4 and two start addresses. On alternate runs the bench delays the grant and toggles outbound ready, so the waits for grant and the back-pressure stalls are exercised next to the free-running cases.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [1:0] SEL_MEM = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_DEV = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  localparam int CTL_GO   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_PATH = 2;
  localparam int CTL_CLR  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_REQ,
    ST_XFER,
    ST_REL
  } seq_st_e;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int CW  = 12,
  parameter int DAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     sel,
  input  logic [DW-1:0]  wdata,
  input  logic           busy,
  output logic [AW-1:0]  mem_base,
  output logic [CW-1:0]  word_cnt,
  output logic [DAW-1:0] dev_addr,
  output logic           dir_m2d,
  output logic           detached,
  output logic           go,
  output logic           clr
);
  logic open_wr;
  logic unused_wdata;

  assign open_wr      = we && !busy;
  assign go           = open_wr && (sel == SEL_CTL) && wdata[CTL_GO];
  assign clr          = we && (sel == SEL_CTL) && wdata[CTL_CLR];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_base <= '0;
      word_cnt <= '0;
      dev_addr <= '0;
      dir_m2d  <= 1'b0;
      detached <= 1'b0;
    end else if (open_wr) begin
      case (sel)
        SEL_MEM: mem_base <= wdata[AW-1:0];
        SEL_CNT: word_cnt <= wdata[CW-1:0];
        SEL_DEV: dev_addr <= wdata[DAW-1:0];
        default: begin
          dir_m2d  <= wdata[CTL_DIR];
          detached <= wdata[CTL_PATH];
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int AW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] addr,
  output logic          rem_zero
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      remaining <= '0;
    end else if (load) begin
      addr      <= base;
      remaining <= count;
    end else if (step) begin
      addr      <= addr + ADDR_ONE;
      remaining <= remaining - CNT_ONE;
    end
  end

  assign rem_zero = (remaining == '0);
endmodule

// File: rtl/dma_sequencer.sv
module dma_sequencer
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic zero_len,
  input  logic dir_m2d,
  input  logic detached,
  input  logic bus_gnt,
  input  logic dev_in_valid,
  input  logic dev_out_ready,
  input  logic rem_zero,
  output logic bus_req,
  output logic busy,
  output logic take_in,
  output logic give_out,
  output logic touch_mem,
  output logic hold_load,
  output logic word_done,
  output logic set_irq
);
  seq_st_e st, st_nx;
  logic    phase, phase_nx;
  logic    need_in, need_out, mem_phase, dev_ok, last_phase, in_xfer, xfer_done;

  always_comb begin
    need_in    = !dir_m2d && !phase;
    need_out   = dir_m2d && (!detached || phase);
    mem_phase  = !detached || (dir_m2d ? !phase : phase);
    last_phase = !detached || phase;
    if (need_in)       dev_ok = dev_in_valid;
    else if (need_out) dev_ok = dev_out_ready;
    else               dev_ok = 1'b1;
  end

  assign in_xfer   = (st == ST_XFER);
  assign xfer_done = in_xfer && dev_ok;
  assign take_in   = in_xfer && need_in;
  assign give_out  = in_xfer && need_out;
  assign touch_mem = in_xfer && mem_phase;
  assign hold_load = xfer_done && detached && !phase;
  assign word_done = xfer_done && last_phase;
  assign bus_req   = (st == ST_REQ) || in_xfer;
  assign busy      = (st != ST_IDLE);

  always_comb begin
    st_nx    = st;
    phase_nx = phase;
    set_irq  = 1'b0;
    case (st)
      ST_IDLE: if (go) begin
        if (zero_len) set_irq = 1'b1;
        else begin
          st_nx    = ST_WAIT;
          phase_nx = 1'b0;
        end
      end
      ST_WAIT: if (dev_ok) st_nx = ST_REQ;
      ST_REQ:  if (bus_gnt) st_nx = ST_XFER;
      ST_XFER: if (dev_ok) st_nx = ST_REL;
      ST_REL: begin
        if (!last_phase) begin
          phase_nx = 1'b1;
          st_nx    = ST_WAIT;
        end else if (rem_zero) begin
          set_irq = 1'b1;
          st_nx   = ST_IDLE;
        end else begin
          phase_nx = 1'b0;
          st_nx    = ST_WAIT;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      phase <= 1'b0;
    end else begin
      st    <= st_nx;
      phase <= phase_nx;
    end
  end
endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine
  import dma_pkg::*;
#(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int CW  = 12,
  parameter int DAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DAW-1:0] dev_addr,
  input  logic           dev_in_valid,
  output logic           dev_in_ready,
  input  logic [DW-1:0]  dev_in_data,
  output logic           dev_out_valid,
  input  logic           dev_out_ready,
  output logic [DW-1:0]  dev_out_data,
  output logic           busy,
  output logic           irq
);
  logic [AW-1:0] mem_base;
  logic [CW-1:0] word_cnt;
  logic          dir_m2d, detached, go, clr;
  logic          rem_zero, take_in, give_out, touch_mem, hold_load, word_done, set_irq;
  logic [DW-1:0] hold_q;

  dma_cfg_regs #(.DW(DW), .AW(AW), .CW(CW), .DAW(DAW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .busy(busy), .mem_base(mem_base), .word_cnt(word_cnt), .dev_addr(dev_addr),
    .dir_m2d(dir_m2d), .detached(detached), .go(go), .clr(clr)
  );

  dma_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(go), .step(word_done),
    .base(mem_base), .count(word_cnt), .addr(mem_addr), .rem_zero(rem_zero)
  );

  dma_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .zero_len(word_cnt == '0),
    .dir_m2d(dir_m2d), .detached(detached), .bus_gnt(bus_gnt),
    .dev_in_valid(dev_in_valid), .dev_out_ready(dev_out_ready),
    .rem_zero(rem_zero), .bus_req(bus_req), .busy(busy), .take_in(take_in),
    .give_out(give_out), .touch_mem(touch_mem), .hold_load(hold_load),
    .word_done(word_done), .set_irq(set_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (hold_load) hold_q <= dir_m2d ? mem_rdata : dev_in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (set_irq) irq <= 1'b1;
    else if (clr)     irq <= 1'b0;
  end

  assign mem_en        = touch_mem;
  assign mem_we        = touch_mem && !dir_m2d;
  assign mem_wdata     = detached ? hold_q : dev_in_data;
  assign dev_in_ready  = take_in;
  assign dev_out_valid = give_out;
  assign dev_out_data  = detached ? hold_q : mem_rdata;
endmodule

// File: rtl/cs_dma_engine_checker.sv
module cs_dma_engine_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [DW-1:0] cfg_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_en,
  input logic          mem_we,
  input logic          dev_in_ready,
  input logic          dev_out_valid,
  input logic          busy,
  input logic          irq
);
  a_r4_mem_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> bus_gnt);

  a_r4_in_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dev_in_ready |-> bus_gnt);

  a_r4_out_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid |-> bus_gnt);

  a_r5_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> !bus_req);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_sel == 2'd3 && cfg_wdata[3])) |=> irq);

  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

bind cs_dma_engine cs_dma_engine_checker #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_en(mem_en), .mem_we(mem_we), .dev_in_ready(dev_in_ready),
  .dev_out_valid(dev_out_valid), .busy(busy), .irq(irq)
);

// File: tb/cs_dma_engine_tb_top.sv
module cs_dma_engine_tb_top;
  localparam int DW = 8, AW = 4, CW = 4, DAW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           cfg_we = 1'b0;
  logic [1:0]     cfg_sel = 2'd0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic           bus_req, bus_gnt;
  logic           mem_en, mem_we;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata, mem_rdata;
  logic [DAW-1:0] dev_addr;
  logic           dev_in_valid, dev_in_ready;
  logic [DW-1:0]  dev_in_data;
  logic           dev_out_valid, dev_out_ready;
  logic [DW-1:0]  dev_out_data;
  logic           busy, irq;

  int n_chk = 0;
  int n_fail = 0;

  // bench models
  logic [DW-1:0] mdl_mem [16];
  logic [DW-1:0] sink [16];
  logic [4:0]    src_idx, sink_n;
  int            grants;
  logic          req_d;
  logic [3:0]    tick;
  logic          mdl_init = 1'b0;
  logic          src_en = 1'b0, sink_en = 1'b0, thr_en = 1'b0;
  int            src_len = 0;
  int            seed = 0;

  function automatic logic [DW-1:0] init_val(input int s, input int a);
    return DW'((a * 7 + s * 3 + 2) ^ 8'h80);
  endfunction

  function automatic logic [DW-1:0] src_val(input int s, input int k);
    return DW'(s * 16 + k * 5 + 1);
  endfunction

  assign mem_rdata     = mdl_mem[mem_addr];
  assign dev_in_valid  = src_en && (int'(src_idx) < src_len);
  assign dev_in_data   = src_val(seed, int'(src_idx));
  assign dev_out_ready = sink_en && (!thr_en || tick[0]);

  always @(posedge clk) begin
    tick <= tick + 4'd1;
    req_d <= bus_req;
    bus_gnt <= bus_req && !mdl_init && (bus_gnt || !thr_en || tick[1]);
    if (mdl_init) begin
      for (int a = 0; a < 16; a++) mdl_mem[a] <= init_val(seed, a);
      src_idx <= '0;
      sink_n  <= '0;
      grants  <= 0;
    end else begin
      if (mem_en && mem_we) mdl_mem[mem_addr] <= mem_wdata;
      if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 5'd1;
      if (dev_out_valid && dev_out_ready) begin
        sink[sink_n[3:0]] <= dev_out_data;
        sink_n <= sink_n + 5'd1;
      end
      if (bus_req && !req_d) grants <= grants + 1;
    end
  end

  initial begin
    tick = '0; req_d = 1'b0; bus_gnt = 1'b0; grants = 0;
    src_idx = '0; sink_n = '0;
  end

  cs_dma_engine #(.DW(DW), .AW(AW), .CW(CW), .DAW(DAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model_reset(input int s);
    seed = s;
    @(negedge clk); mdl_init = 1'b1;
    @(negedge clk); mdl_init = 1'b0;
  endtask

  task automatic wait_irq();
    for (int t = 0; t < 400 && !irq; t++) @(negedge clk);
  endtask

  task automatic run_case(input int det, input int m2d, input int cnt,
                          input int base, input int thr, input int s);
    int exp_g;
    thr_en = thr[0]; src_len = cnt; src_en = 1'b0; sink_en = 1'b0;
    model_reset(s);
    src_en = !m2d[0]; sink_en = m2d[0];
    cfg_write(2'd0, base);
    cfg_write(2'd1, cnt);
    cfg_write(2'd2, s & 15);
    cfg_write(2'd3, 1 | (m2d << 1) | (det << 2));
    if (cnt == 0) begin
      chk(irq == 1'b1, "R8 zero-count irq next cycle", int'(irq), 1);
      repeat (4) @(negedge clk);
      chk(grants == 0, "R8 zero-count no bus request", grants, 0);
    end else begin
      wait_irq();
      chk(irq == 1'b1, "R7 irq after block", int'(irq), 1);
    end
    chk(busy == 1'b0, "R7 idle after block", int'(busy), 0);
    chk(dev_addr == DAW'(s & 15), "R1 peripheral address", int'(dev_addr), s & 15);
    exp_g = det ? 2 * cnt : cnt;
    chk(grants == exp_g, det ? "R3 two grants per word" : "R2 one grant per word",
        grants, exp_g);
    for (int a = 0; a < 16; a++) begin
      int off = (a - base) & 15;
      logic [DW-1:0] ev = (!m2d && off < cnt) ? src_val(s, off) : init_val(s, a);
      chk(mdl_mem[a] == ev, "R6 memory image", int'(mdl_mem[a]), int'(ev));
    end
    if (m2d) begin
      chk(int'(sink_n) == cnt, "R10 outbound word count", int'(sink_n), cnt);
      for (int k = 0; k < cnt; k++)
        chk(sink[k] == init_val(s, (base + k) & 15), "R6 outbound order",
            int'(sink[k]), int'(init_val(s, (base + k) & 15)));
    end else begin
      chk(int'(src_idx) == cnt, "R2 inbound words taken", int'(src_idx), cnt);
    end
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R7 irq held until clear", int'(irq), 1);
    cfg_write(2'd3, 8);
    chk(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s_idx = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b0, "R11 reset bus_req", int'(bus_req), 0);
    chk(mem_en == 1'b0, "R11 reset mem_en", int'(mem_en), 0);
    chk(busy == 1'b0, "R11 reset busy", int'(busy), 0);
    chk(irq == 1'b0, "R11 reset irq", int'(irq), 0);

    for (int det = 0; det < 2; det++)
      for (int m2d = 0; m2d < 2; m2d++)
        for (int cnt = 0; cnt < 5; cnt++)
          for (int bi = 0; bi < 2; bi++) begin
            run_case(det, m2d, cnt, bi ? 13 : 0, (cnt ^ det ^ bi) & 1, s_idx);
            s_idx++;
          end

    // R9 / R4: stalled outbound peripheral, second start and new setup ignored
    thr_en = 1'b0; src_en = 1'b0; sink_en = 1'b0; src_len = 0;
    model_reset(9);
    cfg_write(2'd0, 2);
    cfg_write(2'd1, 4);
    cfg_write(2'd2, 5);
    cfg_write(2'd3, 1 | 2);
    repeat (5) @(negedge clk);
    chk(busy == 1'b1, "R9 busy while stalled", int'(busy), 1);
    chk(bus_req == 1'b0, "R4 no request without ready", int'(bus_req), 0);
    cfg_write(2'd0, 9);
    cfg_write(2'd1, 1);
    cfg_write(2'd2, 11);
    cfg_write(2'd3, 1 | 4);
    chk(dev_addr == DAW'(5), "R9 peripheral address kept", int'(dev_addr), 5);
    sink_en = 1'b1;
    wait_irq();
    chk(int'(sink_n) == 4, "R9 original count kept", int'(sink_n), 4);
    chk(grants == 4, "R9 original path kept", grants, 4);
    for (int k = 0; k < 4; k++)
      chk(sink[k] == init_val(9, 2 + k), "R9 original address kept",
          int'(sink[k]), int'(init_val(9, 2 + k)));
    cfg_write(2'd3, 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule